// File: doc/BRIEF.md
# Software Peripheral Reset Controller

This block owns one active-low reset line for each peripheral that software is allowed to reset. Two register vectors of equal width control the lines. The unlock vector holds one bit per line. The request vector holds one active-low bit per line, and a 0 in it asks for that peripheral to be held in reset. A bit of the request vector can be changed only while its unlock bit is 1. Software can clear an unlock bit but cannot set it again, so a locked line keeps its current request until the next power-on reset.

Two hardware requests override everything software has set up: the life-cycle reset and the system reset request. While either is high, every line is driven low. The register contents are left untouched, so when the hardware request drops, each line returns to the value software programmed. Power-on reset asserts every line and returns both vectors to all ones. The output vector is held in flops, so it cannot glitch, and it reflects a register write at the first clock edge after the write.

Top module: `periph_rst_ctrl`

## Requirements
- R1: While `por_ni` is low, every bit of `periph_rst_no` is 0, the unlock vector is all ones and the request vector is all ones. At the first clock edge after `por_ni` rises, with no hardware request, every output bit becomes 1.
- R2: A write with `wr_sel_i`=1 targets the request vector. For each bit whose unlock bit is 1, the bit takes the written value. With no hardware request, output bit i equals request bit i from the clock edge that accepts the write (0 = peripheral held in reset, 1 = released).
- R3: When an unlock bit is 0, writes leave the matching request bit unchanged. Its reset output and its read-back value keep their previous values.
- R4: A write with `wr_sel_i`=0 targets the unlock vector and clears each bit written as 0. Bits written as 1 keep their current value, so a cleared bit never returns to 1 by a write.
- R5: A power-on reset returns every cleared unlock bit to 1 and every request bit to 1.
- R6: When `lc_rst_req_i` or `sys_rst_req_i` is high at a clock edge, every output bit is 0 after that edge, and the register vectors are not modified. After the request is removed, the outputs follow the request vector again from the next edge.
- R7: Each bit pair works independently: a write changes only the request bits whose own unlock bit is 1, and changes no other output.
- R8: `rd_data_o` returns, combinationally, the unlock vector when `rd_sel_i`=0 and the request vector when `rd_sel_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, asynchronous, active low |
| lc_rst_req_i | input | 1 | Life-cycle reset request, active high |
| sys_rst_req_i | input | 1 | System reset request, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 unlock vector, 1 request vector |
| wr_data_i | input | N_PERIPH | Write data |
| rd_sel_i | input | 1 | Read target: 0 unlock vector, 1 request vector |
| rd_data_o | output | N_PERIPH | Read data |
| periph_rst_no | output | N_PERIPH | Peripheral reset lines, active low |

## Verification
Register writes and hardware requests show up on `periph_rst_no` exactly one edge after they are presented. Read-back reflects a write after that same edge, and changes with `rd_sel_i` with no clock at all. The bench drives every input a short time after a rising edge. It then checks the outputs and both read-back vectors 1 ns after the following edge, against a reference model that it has advanced by one step. Each check therefore lands on the first cycle in which the result is due, and never straddles an edge.

// File: rtl/periph_rst_pkg.sv
package periph_rst_pkg;

    // Register target selector shared by the write and read ports
    typedef enum logic {
        SEL_UNLOCK  = 1'b0,
        SEL_REQUEST = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/periph_rst_regs.sv
module periph_rst_regs
    import periph_rst_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         por_ni,
    input  logic         wr_en_i,
    input  reg_sel_e     wr_sel_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] unlock_q_o,
    output logic [N-1:0] req_q_o,
    output logic [N-1:0] req_d_o
);

    typedef struct packed {
        logic [N-1:0] unlock;
        logic [N-1:0] req;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_UNLOCK: begin
                    // write-zero-to-clear, ones are ignored
                    st_d.unlock = st_q.unlock & wr_data_i;
                end
                SEL_REQUEST: begin
                    // locked bits keep their value
                    st_d.req = (st_q.req & ~st_q.unlock) | (wr_data_i & st_q.unlock);
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q.unlock <= '1;
            st_q.req    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlock_q_o = st_q.unlock;
    assign req_q_o    = st_q.req;
    assign req_d_o    = st_d.req;

endmodule

// File: rtl/periph_rst_drive.sv
module periph_rst_drive #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         por_ni,
    input  logic         hw_req_i,
    input  logic [N-1:0] req_next_i,
    output logic [N-1:0] rst_no
);

    logic [N-1:0] rst_d, rst_q;

    // one flop per line; a hardware request wins over software
    for (genvar i = 0; i < N; i++) begin : g_line
        always_comb begin
            rst_d[i] = req_next_i[i] & ~hw_req_i;
        end

        always_ff @(posedge clk_i or negedge por_ni) begin
            if (!por_ni) rst_q[i] <= 1'b0;
            else         rst_q[i] <= rst_d[i];
        end
    end

    assign rst_no = rst_q;

endmodule

// File: rtl/periph_rst_ctrl.sv
module periph_rst_ctrl
    import periph_rst_pkg::*;
#(
    parameter int N_PERIPH = 8
) (
    input  logic                clk_i,
    input  logic                por_ni,
    input  logic                lc_rst_req_i,
    input  logic                sys_rst_req_i,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [N_PERIPH-1:0] wr_data_i,
    input  logic                rd_sel_i,
    output logic [N_PERIPH-1:0] rd_data_o,
    output logic [N_PERIPH-1:0] periph_rst_no
);

    localparam int N = N_PERIPH;

    logic [N-1:0] unlock_q, req_q, req_d;
    logic         hw_req;

    assign hw_req = lc_rst_req_i | sys_rst_req_i;

    periph_rst_regs #(.N(N)) u_regs (
        .clk_i      (clk_i),
        .por_ni     (por_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (reg_sel_e'(wr_sel_i)),
        .wr_data_i  (wr_data_i),
        .unlock_q_o (unlock_q),
        .req_q_o    (req_q),
        .req_d_o    (req_d)
    );

    periph_rst_drive #(.N(N)) u_drive (
        .clk_i      (clk_i),
        .por_ni     (por_ni),
        .hw_req_i   (hw_req),
        .req_next_i (req_d),
        .rst_no     (periph_rst_no)
    );

    always_comb begin
        rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_REQUEST) ? req_q : unlock_q;
    end

endmodule

// File: rtl/periph_rst_ctrl_chk.sv
module periph_rst_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk_i,
    input logic         por_ni,
    input logic         lc_req,
    input logic         sys_req,
    input logic [N-1:0] unlock_q,
    input logic [N-1:0] req_q,
    input logic [N-1:0] rst_no
);

    // R1
    por_state_chk: assert property (@(posedge clk_i)
        !por_ni |-> (rst_no == '0 && unlock_q == '1 && req_q == '1));

    // R6
    hw_req_asserts_all_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (lc_req || sys_req) |=> (rst_no == '0));

    // R2
    out_follows_req_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        !(lc_req || sys_req) |=> (rst_no == req_q));

    // R4
    unlock_never_sets_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        1'b1 |=> ((unlock_q & ~$past(unlock_q)) == '0));

    // R3
    locked_req_stable_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        1'b1 |=> (((req_q ^ $past(req_q)) & ~$past(unlock_q)) == '0));

endmodule

bind periph_rst_ctrl periph_rst_ctrl_chk #(.N(N_PERIPH)) u_chk (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .lc_req   (lc_rst_req_i),
    .sys_req  (sys_rst_req_i),
    .unlock_q (unlock_q),
    .req_q    (req_q),
    .rst_no   (periph_rst_no)
);

// File: tb/periph_rst_ctrl_bench.sv
`timescale 1ns/1ps
module periph_rst_ctrl_bench;

    localparam int N = 8;

    logic         clk_i = 1'b0;
    logic         por_ni = 1'b1;
    logic         lc_rst_req_i = 1'b0;
    logic         sys_rst_req_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic         wr_sel_i = 1'b0;
    logic [N-1:0] wr_data_i = '0;
    logic         rd_sel_i = 1'b0;
    logic [N-1:0] rd_data_o;
    logic [N-1:0] periph_rst_no;

    int total = 0;
    int bad   = 0;

    logic [N-1:0] m_unlock, m_req, m_out;

    always #4 clk_i = ~clk_i;

    periph_rst_ctrl #(.N_PERIPH(N)) u_periph_rst_ctrl (
        .clk_i         (clk_i),
        .por_ni        (por_ni),
        .lc_rst_req_i  (lc_rst_req_i),
        .sys_rst_req_i (sys_rst_req_i),
        .wr_en_i       (wr_en_i),
        .wr_sel_i      (wr_sel_i),
        .wr_data_i     (wr_data_i),
        .rd_sel_i      (rd_sel_i),
        .rd_data_o     (rd_data_o),
        .periph_rst_no (periph_rst_no)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] next_req(input logic [N-1:0] req, input logic [N-1:0] unl,
                                              input logic [N-1:0] data);
        return (req & ~unl) | (data & unl);
    endfunction

    // Drive one cycle, advance the model, check after the edge
    task automatic cycle(input logic we, input logic sel, input logic [N-1:0] data,
                         input logic lc, input logic sys, input string req);
        wr_en_i = we; wr_sel_i = sel; wr_data_i = data;
        lc_rst_req_i = lc; sys_rst_req_i = sys;
        if (we && !sel) m_unlock = m_unlock & data;
        else if (we && sel) m_req = next_req(m_req, m_unlock, data);
        m_out = (lc || sys) ? '0 : m_req;
        @(posedge clk_i); #1;
        check({req, " out"}, periph_rst_no, m_out);
        rd_sel_i = 1'b0; #1;
        check("R8 unlock readback", rd_data_o, m_unlock);
        rd_sel_i = 1'b1; #1;
        check("R8 request readback", rd_data_o, m_req);
    endtask

    task automatic do_por();
        por_ni = 1'b0;
        repeat (3) @(posedge clk_i);
        #1;
        check("R1 out during por", periph_rst_no, '0);
        rd_sel_i = 1'b0; #1;
        check("R1 unlock during por", rd_data_o, '1);
        rd_sel_i = 1'b1; #1;
        check("R1 request during por", rd_data_o, '1);
        por_ni = 1'b1;
        m_unlock = '1; m_req = '1;
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #2;
        do_por();
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 release");

        // R2 directed: assert then release, one edge latency
        cycle(1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, "R2 write 0xA5");
        cycle(1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, "R2 release all");
        // R4: writing ones does not set, zeros clear
        cycle(1'b1, 1'b0, 8'hF7, 1'b0, 1'b0, "R4 clear bit3");
        cycle(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, "R4 ones no set");
        // R3 / R7: bit3 locked at 1, others follow
        cycle(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R3 R7 masked bit3");
        // lock bit0 while asserted, then try release
        cycle(1'b1, 1'b0, 8'hFE, 1'b0, 1'b0, "R7 clear bit0");
        cycle(1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, "R3 locked bit0 stays asserted");
        // R6: hardware requests override, registers untouched
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b0, "R6 lc req");
        cycle(1'b1, 1'b1, 8'h0F, 1'b0, 1'b1, "R6 sys req with write");
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 after release");
        // R5: por restores unlock bits
        do_por();
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 after por");

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic we  = ($urandom % 4) != 0;
            logic sel = ($urandom % 5) != 0;
            logic [N-1:0] d = N'($urandom);
            logic lc  = ($urandom % 10) == 0;
            logic sys = ($urandom % 10) == 0;
            if (!sel) d = d | N'($urandom) | N'($urandom);
            if (k == 300) begin
                do_por();
            end
            cycle(we, sel, d, lc, sys, "R2 R3 R6 R7 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule